// File: doc/BRIEF.md
# Two-Channel Register-Mapped PWM Controller

This block holds two identical waveform channels behind a simple 32-bit register bus. Each channel has a phase-accumulating frequency generator. Its accumulator MSB is a square wave whose frequency is set by a 16-bit tuning word. Each rising edge of that square wave advances a small period counter, and the counter produces a pulse-width waveform with a programmable period and high time. A per-channel select bit chooses which of the two waveforms appears on the channel pin. Shared control registers carry the run, force-high, output-disable and open-drain controls for each channel.

The 16-bit tuning word is written as two byte-wide registers. The generator switches to the new value only once both halves have been written, in either order, so it never runs on a half-updated word. The per-channel control bits sit in 4-bit fields inside the shared registers. Channel n starts at bit 4n.

Top module: `pwmc_top`

## Requirements
- R1: After reset every register reads zero, both pins are low, and both pin drivers are enabled (output-disable bit clear).
- R2: Address 0x00 holds the control fields (bits 7:0 stored, bit 4n+0 run, 4n+1 output-disable, 4n+2 force-high, 4n+3 open-drain). Address 0x04 holds the mode bits at positions 4n (only bits 0 and 4 stored). The tuning high byte is at 0x08+8n, the tuning low byte at 0x0C+8n, the high time at 0x18+8n and the period at 0x1C+8n, each 8 bits wide. A read returns the stored value one cycle after the read strobe, with bits that are not stored reading zero. Without a read strobe, read data is zero.
- R3: An address not listed in R2, including any address that is not a multiple of 4, reads zero and ignores writes.
- R4: A channel's active tuning word changes only when both of its bytes have been written since the last change, in either order. It then takes the value {high byte, low byte}.
- R5: While running, a channel's accumulator adds the active tuning word modulo 2^16 every clock, and the square wave is the accumulator MSB. A word of 2^k gives a square period of 2^(16-k) clocks.
- R6: The period counter advances on each rising edge of the square wave and returns to 0 after reaching the period value, so one cycle lasts period+1 edges. The waveform is high while the count is below the high time. A high time of 0 keeps it low, and a high time above the period keeps it high.
- R7: Mode bit 1 puts the pulse-width waveform on the pin. Mode bit 0 puts the square wave on the pin.
- R8: With the run bit clear, the accumulator and counter are held at zero and the pin is low unless force-high is set.
- R9: Force-high drives the pin level to 1 whatever the run and mode bits are.
- R10: With the output-disable bit set, the pin driver enable is 0.
- R11: With open-drain set, the driver is enabled only while the pin level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| pwm_out | output | 2 | Pin level per channel |
| pwm_oe | output | 2 | Pin driver enable per channel |

## Verification
The assertions assume the bus strobes are clean synchronous pulses. They also assume that the address is stable in the cycle the strobe is sampled, and that read and write never target different registers in the same cycle. The stimulus drives every bus field on the falling edge and issues one access at a time, separated by an idle cycle. The tuning-word hold property assumes the active word changes only through bus writes. The bench never forces internal state, so every change in the word comes from a completed byte pair.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int BUS_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int CW_W      = 2 * BYTE_W;
  localparam int CNT_W     = 8;
  localparam int FIELD_W   = 4;
  localparam int CH_STRIDE = 8;
  localparam int CW_BASE   = 8;
  localparam int B_RUN     = 0;
  localparam int B_OEB     = 1;
  localparam int B_FHI     = 2;
  localparam int B_OD      = 3;

  function automatic int cw_hi_addr(int ch);
    return CW_BASE + CH_STRIDE * ch;
  endfunction

  function automatic int cw_lo_addr(int ch);
    return CW_BASE + 4 + CH_STRIDE * ch;
  endfunction

  function automatic int on_addr(int ch, int nch);
    return CW_BASE + CH_STRIDE * nch + CH_STRIDE * ch;
  endfunction

  function automatic int per_addr(int ch, int nch);
    return on_addr(ch, nch) + 4;
  endfunction

  function automatic int map_end(int nch);
    return CW_BASE + 2 * CH_STRIDE * nch;
  endfunction

  // next period count on a square-wave edge
  function automatic logic [CNT_W-1:0] count_step(logic [CNT_W-1:0] cnt,
                                                  logic [CNT_W-1:0] per);
    return (cnt >= per) ? '0 : cnt + 1'b1;
  endfunction

  function automatic logic duty_level(logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] hi_time);
    return cnt < hi_time;
  endfunction

  function automatic logic pin_level(logic run, logic fhi, logic sel, logic sq, logic wave);
    if (fhi) return 1'b1;
    if (!run) return 1'b0;
    return sel ? wave : sq;
  endfunction

  function automatic logic drive_enable(logic oeb, logic od, logic lvl);
    return !oeb && !(od && lvl);
  endfunction
endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wr_en,
  input  logic [BUS_W-1:0]               wr_data,
  input  logic                           rd_en,
  output logic [BUS_W-1:0]               rd_data,
  output logic [NUM_CH-1:0]              run_o,
  output logic [NUM_CH-1:0]              oeb_o,
  output logic [NUM_CH-1:0]              fhi_o,
  output logic [NUM_CH-1:0]              od_o,
  output logic [NUM_CH-1:0]              sel_o,
  output logic [NUM_CH-1:0]              commit_o,
  output logic [NUM_CH-1:0][CW_W-1:0]    cw_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   on_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   per_o
);
  localparam int CTRL_BITS = FIELD_W * NUM_CH;
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(4);

  logic [CTRL_BITS-1:0]             ctrl_q;
  logic [NUM_CH-1:0]                sel_q;
  logic [NUM_CH-1:0][BYTE_W-1:0]    hi_q, lo_q;
  logic [NUM_CH-1:0][CNT_W-1:0]     on_q, per_q;
  logic [NUM_CH-1:0][CW_W-1:0]      act_q;
  logic [NUM_CH-1:0]                hi_seen_q, lo_seen_q;
  logic                             hit_ctrl, hit_sel;
  logic [NUM_CH-1:0]                hit_hi, hit_lo, hit_on, hit_per;
  logic [BUS_W-1:0]                 rd_mux;
  logic                             unused_wr_top;

  assign unused_wr_top = ^wr_data[BUS_W-1:CTRL_BITS];

  always_comb begin
    hit_ctrl = (addr == A_CTRL);
    hit_sel  = (addr == A_SEL);
    for (int i = 0; i < NUM_CH; i++) begin
      hit_hi[i]  = (addr == ADDR_W'(cw_hi_addr(i)));
      hit_lo[i]  = (addr == ADDR_W'(cw_lo_addr(i)));
      hit_on[i]  = (addr == ADDR_W'(on_addr(i, NUM_CH)));
      hit_per[i] = (addr == ADDR_W'(per_addr(i, NUM_CH)));
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux[CTRL_BITS-1:0] = ctrl_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_sel)    rd_mux[FIELD_W*i]    = sel_q[i];
      if (hit_hi[i])  rd_mux[BYTE_W-1:0]   = hi_q[i];
      if (hit_lo[i])  rd_mux[BYTE_W-1:0]   = lo_q[i];
      if (hit_on[i])  rd_mux[CNT_W-1:0]    = on_q[i];
      if (hit_per[i]) rd_mux[CNT_W-1:0]    = per_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      ctrl_q    <= '0;
      sel_q     <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      on_q      <= '0;
      per_q     <= '0;
      act_q     <= '0;
      hi_seen_q <= '0;
      lo_seen_q <= '0;
    end else begin
      rd_data <= rd_en ? rd_mux : '0;
      if (wr_en && hit_ctrl) ctrl_q <= wr_data[CTRL_BITS-1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_en && hit_sel)    sel_q[i] <= wr_data[FIELD_W*i];
        if (wr_en && hit_on[i])  on_q[i]  <= wr_data[CNT_W-1:0];
        if (wr_en && hit_per[i]) per_q[i] <= wr_data[CNT_W-1:0];
        if (wr_en && hit_hi[i]) begin
          hi_q[i] <= wr_data[BYTE_W-1:0];
          if (lo_seen_q[i]) begin
            act_q[i]     <= {wr_data[BYTE_W-1:0], lo_q[i]};
            hi_seen_q[i] <= 1'b0;
            lo_seen_q[i] <= 1'b0;
          end else begin
            hi_seen_q[i] <= 1'b1;
          end
        end
        if (wr_en && hit_lo[i]) begin
          lo_q[i] <= wr_data[BYTE_W-1:0];
          if (hi_seen_q[i]) begin
            act_q[i]     <= {hi_q[i], wr_data[BYTE_W-1:0]};
            hi_seen_q[i] <= 1'b0;
            lo_seen_q[i] <= 1'b0;
          end else begin
            lo_seen_q[i] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      run_o[i]    = ctrl_q[FIELD_W*i + B_RUN];
      oeb_o[i]    = ctrl_q[FIELD_W*i + B_OEB];
      fhi_o[i]    = ctrl_q[FIELD_W*i + B_FHI];
      od_o[i]     = ctrl_q[FIELD_W*i + B_OD];
      commit_o[i] = wr_en && ((hit_hi[i] && lo_seen_q[i]) || (hit_lo[i] && hi_seen_q[i]));
    end
  end

  assign sel_o = sel_q;
  assign cw_o  = act_q;
  assign on_o  = on_q;
  assign per_o = per_q;
endmodule

// File: rtl/pwmc_nco.sv
module pwmc_nco #(
  parameter int CW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [CW_W-1:0] cw,
  output logic            sq_o,
  output logic            rise_o
);
  logic [CW_W-1:0] acc_q;
  logic            prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      prev_q <= 1'b0;
    end else if (!run) begin
      acc_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      acc_q  <= acc_q + cw;
      prev_q <= acc_q[CW_W-1];
    end
  end

  assign sq_o   = acc_q[CW_W-1];
  assign rise_o = run && sq_o && !prev_q;
endmodule

// File: rtl/pwmc_stage.sv
module pwmc_stage
  import pwmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rise,
  input  logic [CNT_W-1:0] hi_time,
  input  logic [CNT_W-1:0] per,
  output logic             wave_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (rise)   cnt_q <= count_step(cnt_q, per);
  end

  assign wave_o = duty_level(cnt_q, hi_time);
endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  logic [NUM_CH-1:0]              run_w, oeb_w, fhi_w, od_w, sel_w, commit_w;
  logic [NUM_CH-1:0]              sq_w, rise_w, wave_w;
  logic [NUM_CH-1:0][CW_W-1:0]    cw_w;
  logic [NUM_CH-1:0][CNT_W-1:0]   on_w, per_w;

  pwmc_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr_en    (bus_wr),
    .wr_data  (bus_wdata),
    .rd_en    (bus_rd),
    .rd_data  (bus_rdata),
    .run_o    (run_w),
    .oeb_o    (oeb_w),
    .fhi_o    (fhi_w),
    .od_o     (od_w),
    .sel_o    (sel_w),
    .commit_o (commit_w),
    .cw_o     (cw_w),
    .on_o     (on_w),
    .per_o    (per_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwmc_nco #(.CW_W(CW_W)) u_nco (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_w[g]),
      .cw     (cw_w[g]),
      .sq_o   (sq_w[g]),
      .rise_o (rise_w[g])
    );

    pwmc_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_w[g]),
      .rise    (rise_w[g]),
      .hi_time (on_w[g]),
      .per     (per_w[g]),
      .wave_o  (wave_w[g])
    );

    assign pwm_out[g] = pin_level(run_w[g], fhi_w[g], sel_w[g], sq_w[g], wave_w[g]);
    assign pwm_oe[g]  = drive_enable(oeb_w[g], od_w[g], pwm_out[g]);
  end
endmodule

// File: rtl/pwmc_chk.sv
module pwmc_chk
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           addr,
  input logic                        rd_en,
  input logic [31:0]                 rd_data,
  input logic [NUM_CH-1:0]           pwm_out,
  input logic [NUM_CH-1:0]           pwm_oe,
  input logic [NUM_CH-1:0]           run,
  input logic [NUM_CH-1:0]           oeb,
  input logic [NUM_CH-1:0]           fhi,
  input logic [NUM_CH-1:0]           od,
  input logic [NUM_CH-1:0]           commit,
  input logic [NUM_CH-1:0][CW_W-1:0] cw_act
);
  logic unmapped;
  assign unmapped = (addr[1:0] != 2'b00) || (int'(addr) >= map_end(NUM_CH));

  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == 32'd0));

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rd_data == 32'd0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ap
    p_cw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit[g] |=> $stable(cw_act[g]));

    p_stop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[g] && !fhi[g]) |-> !pwm_out[g]);

    p_force_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fhi[g] |-> pwm_out[g]);

    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      oeb[g] |-> !pwm_oe[g]);

    p_od_no_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (od[g] && pwm_oe[g]) |-> !pwm_out[g]);
  end
endmodule

bind pwmc_top pwmc_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (bus_addr),
  .rd_en   (bus_rd),
  .rd_data (bus_rdata),
  .pwm_out (pwm_out),
  .pwm_oe  (pwm_oe),
  .run     (run_w),
  .oeb     (oeb_w),
  .fhi     (fhi_w),
  .od      (od_w),
  .commit  (commit_w),
  .cw_act  (cw_w)
);

// File: tb/tb_pwmc_top.sv
module tb_pwmc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out, pwm_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_ctrl, m_sel;
  int m_hi[2], m_lo[2], m_on[2], m_per[2], m_act[2];
  bit m_hs[2], m_ls[2];
  int m_acc[2], m_cnt[2];
  bit m_prev[2];
  logic [31:0] m_rd;

  pwmc_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always #10 clk = ~clk;

  function automatic int model_read(int a);
    if (a % 4 != 0) return 0;
    if (a == 0) return m_ctrl;
    if (a == 4) return m_sel;
    if (a >= 8 && a < 24) return ((a - 8) % 8 == 0) ? m_hi[(a-8)/8] : m_lo[(a-8)/8];
    if (a >= 24 && a < 40) return ((a - 24) % 8 == 0) ? m_on[(a-24)/8] : m_per[(a-24)/8];
    return 0;
  endfunction

  task automatic model_write(int a, int d);
    int ch;
    if (a % 4 != 0) return;
    if (a == 0) m_ctrl = d & 8'hFF;
    else if (a == 4) m_sel = d & 8'h11;
    else if (a >= 8 && a < 24) begin
      ch = (a - 8) / 8;
      if ((a - 8) % 8 == 0) begin
        m_hi[ch] = d & 255;
        if (m_ls[ch]) begin m_act[ch] = m_hi[ch] * 256 + m_lo[ch]; m_ls[ch] = 0; m_hs[ch] = 0; end
        else m_hs[ch] = 1;
      end else begin
        m_lo[ch] = d & 255;
        if (m_hs[ch]) begin m_act[ch] = m_hi[ch] * 256 + m_lo[ch]; m_ls[ch] = 0; m_hs[ch] = 0; end
        else m_ls[ch] = 1;
      end
    end else if (a >= 24 && a < 40) begin
      ch = (a - 24) / 8;
      if ((a - 24) % 8 == 0) m_on[ch] = d & 255; else m_per[ch] = d & 255;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_sel = 0; m_rd = '0;
      for (int c = 0; c < 2; c++) begin
        m_hi[c] = 0; m_lo[c] = 0; m_on[c] = 0; m_per[c] = 0; m_act[c] = 0;
        m_hs[c] = 0; m_ls[c] = 0; m_acc[c] = 0; m_cnt[c] = 0; m_prev[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (((m_ctrl >> (4*c)) & 1) == 0) begin
          m_acc[c] = 0; m_cnt[c] = 0; m_prev[c] = 0;
        end else begin
          bit msb;
          msb = ((m_acc[c] >> 15) & 1) != 0;
          if (msb && !m_prev[c]) m_cnt[c] = (m_cnt[c] >= m_per[c]) ? 0 : m_cnt[c] + 1;
          m_prev[c] = msb;
          m_acc[c] = (m_acc[c] + m_act[c]) % 65536;
        end
      end
      m_rd = bus_rd ? 32'(model_read(int'(bus_addr))) : 32'd0;
      if (bus_wr) model_write(int'(bus_addr), int'(bus_wdata & 32'hFF));
    end
  end

  function automatic bit exp_out(int c);
    int f;
    f = (m_ctrl >> (4*c)) & 15;
    if ((f & 4) != 0) return 1'b1;
    if ((f & 1) == 0) return 1'b0;
    if (((m_sel >> (4*c)) & 1) != 0) return m_cnt[c] < m_on[c];
    return ((m_acc[c] >> 15) & 1) != 0;
  endfunction

  function automatic bit exp_oe(int c);
    int f;
    f = (m_ctrl >> (4*c)) & 15;
    if ((f & 2) != 0) return 1'b0;
    if ((f & 8) != 0 && exp_out(c)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 2; c++) begin
        chk(cur_req, "pin level", 32'(pwm_out[c]), 32'(exp_out(c)));
        chk(cur_req, "driver enable", 32'(pwm_oe[c]), 32'(exp_oe(c)));
      end
      chk("R2", "read data", bus_rdata, m_rd);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 8'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic measure(int c, int n, output int rises, output int highs);
    bit last;
    rises = 0; highs = 0;
    @(negedge clk);
    last = pwm_out[c];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[c] && !last) rises++;
      if (pwm_out[c]) highs++;
      last = pwm_out[c];
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int r, h, mism;
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 40; a += 4) begin
      rd(a, v); chk("R1", "reset register", v, 32'd0);
    end
    chk("R1", "reset pins", 32'(pwm_out), 32'd0);
    chk("R1", "reset enables", 32'(pwm_oe), 32'd3);

    // R2 storage widths and read-back
    cur_req = "R2";
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2", "control width", v, 32'hFF);
    wr(0, 0);
    wr(4, 32'hFFFF_FFFF); rd(4, v); chk("R2", "mode bits", v, 32'h11);
    wr(4, 0);
    wr(24, 32'h1234); rd(24, v); chk("R2", "high time byte", v, 32'h34);
    wr(36, 32'hA5); rd(36, v); chk("R2", "ch1 period", v, 32'hA5);
    wr(24, 0); wr(36, 0);

    // R3 unmapped addresses
    cur_req = "R3";
    wr(40, 32'hFF); wr(2, 32'hFF); wr(252, 32'hFF);
    rd(40, v);  chk("R3", "unmapped read", v, 32'd0);
    rd(2, v);   chk("R3", "misaligned read", v, 32'd0);
    rd(0, v);   chk("R3", "control untouched", v, 32'd0);
    rd(252, v); chk("R3", "top address read", v, 32'd0);

    // R4 two-byte tuning commit, high then low, then low then high
    cur_req = "R4";
    wr(0, 32'h1);
    wr(8, 32'h40); settle(4);
    measure(0, 20, r, h); chk("R4", "half-written word inactive", 32'(r), 32'd0);
    rd(8, v); chk("R4", "high byte stored", v, 32'h40);
    wr(12, 32'h00); settle(4);
    measure(0, 64, r, h); chk("R4", "0x4000 rises", 32'(r), 32'd16);
    wr(12, 32'h00); settle(4);
    measure(0, 64, r, h); chk("R4", "low-only no change", 32'(r), 32'd16);
    wr(8, 32'h80); settle(4);
    measure(0, 64, r, h); chk("R4", "0x8000 rises", 32'(r), 32'd32);

    // R5 square wave frequency
    cur_req = "R5";
    wr(8, 32'h20); wr(12, 32'h00); settle(8);
    measure(0, 64, r, h);
    chk("R5", "0x2000 rises", 32'(r), 32'd8);
    chk("R5", "0x2000 half duty", 32'(h), 32'd32);

    // R6 and R7 pulse-width waveform
    cur_req = "R6";
    wr(8, 32'h80); wr(12, 32'h00);
    wr(28, 3); wr(24, 2); wr(4, 32'h1); settle(16);
    measure(0, 64, r, h);
    chk("R7", "pwm selected rises", 32'(r), 32'd8);
    chk("R6", "2 of 4 high", 32'(h), 32'd32);
    wr(24, 0); settle(16);
    measure(0, 64, r, h); chk("R6", "zero high time", 32'(h), 32'd0);
    wr(24, 9); settle(16);
    measure(0, 64, r, h); chk("R6", "high time above period", 32'(h), 32'd64);
    cur_req = "R7";
    wr(4, 0); settle(4);
    measure(0, 64, r, h); chk("R7", "square selected", 32'(r), 32'd32);
    wr(4, 32'h1);

    // R8 stopped
    cur_req = "R8";
    wr(0, 0); settle(2);
    measure(0, 32, r, h); chk("R8", "stopped low", 32'(h), 32'd0);

    // R9 force-high
    cur_req = "R9";
    wr(0, 32'h4); settle(2);
    measure(0, 32, r, h); chk("R9", "forced stopped", 32'(h), 32'd32);
    wr(24, 0); wr(0, 32'h5); settle(8);
    measure(0, 32, r, h); chk("R9", "forced running", 32'(h), 32'd32);

    // R10 output disable
    cur_req = "R10";
    wr(0, 32'h2); settle(2);
    chk("R10", "ch0 driver off", 32'(pwm_oe[0]), 32'd0);
    chk("R10", "ch1 driver on", 32'(pwm_oe[1]), 32'd1);

    // R11 open drain
    cur_req = "R11";
    wr(0, 32'hC); settle(2);
    chk("R11", "od high released", 32'(pwm_oe[0]), 32'd0);
    wr(0, 32'h8); settle(2);
    chk("R11", "od low level", 32'(pwm_out[0]), 32'd0);
    chk("R11", "od low driven", 32'(pwm_oe[0]), 32'd1);
    wr(16, 32'h80); wr(20, 32'h00); wr(4, 0);
    wr(0, 32'h90); settle(4);
    mism = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (pwm_oe[1] == pwm_out[1]) mism++;
    end
    chk("R11", "ch1 enable tracks low level", 32'(mism), 32'd0);
    measure(1, 64, r, h); chk("R5", "ch1 square rises", 32'(r), 32'd32);
    cur_req = "R10";
    wr(0, 32'h20); settle(2);
    chk("R10", "ch1 disabled", 32'(pwm_oe[1]), 32'd0);
    chk("R8", "ch1 stopped", 32'(pwm_out[1]), 32'd0);

    settle(4);
    finish_run();
  end
endmodule